// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Stall Controller

This block is the hazard controller for an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. Each cycle the datapath presents the instruction sitting in decode: its two source register numbers, its destination, its write enable, whether it is a load, whether it is a branch and, for a branch, the outcome the decode-stage comparator computed. The controller keeps its own shadow copy of the destinations of the three older instructions in execute, memory and writeback. It compares these against the decode sources and drives the fetch hold, the execute bubble, the decode flush, the branch redirect and the forwarding selects.

A parameter chooses between two pipeline variants. In the plain variant nothing is forwarded, so a consumer waits in decode until its producer reaches writeback. Branches are not delayed, and the fetch slot stays idle while a branch is in decode. In the forwarding variant, results are forwarded to the execute stage and to the decode-stage branch comparator. Here a branch has one delay slot that always executes. Only load-use and branch-operand cases still stall. A write in writeback and a read in decode may fall in the same cycle without a stall in either variant, because the register file writes before it reads.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is asserted and afterwards, before any valid decode instruction, the shadow stages are empty and every output is 0 (fetch_hold, idex_bubble, ifid_flush, pc_redirect, br_fwd_a/b low; ex_fwd_a/b = 2'b00).
- R2: With FWD_MODE=0, a valid decode instruction stalls if either source register is the destination of a writing instruction in execute or memory. A stall raises fetch_hold and idex_bubble together, and the execute stage holds no instruction in the next cycle.
- R3: A writing instruction in writeback never causes a stall, in either mode.
- R4: Register 0 is never a dependence, and a producer whose write enable is low is never a dependence.
- R5: With FWD_MODE=0, a valid branch in decode that is not stalled raises ifid_flush. Not taken, it also raises fetch_hold with pc_redirect low. Taken, it raises pc_redirect with fetch_hold low.
- R6: With FWD_MODE=1, ifid_flush stays low. A taken, unstalled branch raises pc_redirect with fetch_hold low, so the instruction fetched in that cycle (the delay slot) proceeds.
- R7: With FWD_MODE=1, a non-branch decode instruction stalls only when a source is written by a load in execute, and that stall lasts one cycle.
- R8: With FWD_MODE=1, a branch in decode stalls if a source is written by any instruction in execute, or by a load in memory. A source written by a non-load in memory is taken from memory instead, signalled by br_fwd_a (first source) or br_fwd_b (second source) = 1.
- R9: ex_fwd_a / ex_fwd_b select the first / second operand of the execute-stage instruction: 2'b01 takes the memory-stage result, 2'b10 takes the writeback-stage result, and 2'b00 takes the register file. Memory has priority over writeback. With FWD_MODE=0 both are always 2'b00.
- R10: In a scripted sequence of twelve instructions, each instruction enters execute and writeback in the cycle the per-mode stage tables predict.
- R11: While stalled, ifid_flush and pc_redirect are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_rd | input | REG_W | Destination register of the decode instruction |
| id_wen | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| br_taken | input | 1 | Branch comparison result from decode |
| fetch_hold | output | 1 | Hold the PC and the fetch/decode register |
| idex_bubble | output | 1 | Load an empty instruction into execute |
| ifid_flush | output | 1 | Load an empty instruction into decode (overrides hold) |
| pc_redirect | output | 1 | Load the branch target into the PC |
| ex_fwd_a | output | 2 | Operand source select for the execute-stage first operand |
| ex_fwd_b | output | 2 | Operand source select for the execute-stage second operand |
| br_fwd_a | output | 1 | Branch comparator first source from the memory stage |
| br_fwd_b | output | 1 | Branch comparator second source from the memory stage |

## Verification
One scripted program runs on both variants side by side. It contains an ALU-to-load address dependence, a load-to-ALU dependence, and a branch that waits on an ALU result. It also has a not-taken branch and a taken branch whose following instruction is either discarded or kept as a delay slot. These separate the plain variant's two-cycle waits from the forwarding variant's single load-use bubble and its branch waits. A cycle model in the bench predicts every output each clock. A tail of instructions that write register 0, or that name a destination without enabling the write, shows that neither kind triggers a stall. The stage tables recorded for the first eight instructions are compared against hand-worked entry cycles for execute and writeback.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand source for an execute-stage operand.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] id_rd,
  input  logic             id_wen,
  input  logic             id_load,
  input  logic             insert_bubble,
  output logic             ex_v,
  output logic             ex_wen,
  output logic             ex_load,
  output logic [REG_W-1:0] ex_rd,
  output logic [REG_W-1:0] ex_rs,
  output logic [REG_W-1:0] ex_rt,
  output logic             mem_v,
  output logic             mem_wen,
  output logic             mem_load,
  output logic [REG_W-1:0] mem_rd,
  output logic             wb_v,
  output logic             wb_wen,
  output logic [REG_W-1:0] wb_rd
);

  // An instruction enters execute only when decode is valid and not held.
  logic advance_into_ex;
  assign advance_into_ex = id_valid && !insert_bubble;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_v    <= 1'b0;
      ex_wen  <= 1'b0;
      ex_load <= 1'b0;
      ex_rd   <= '0;
      ex_rs   <= '0;
      ex_rt   <= '0;
      mem_v   <= 1'b0;
      mem_wen <= 1'b0;
      mem_load<= 1'b0;
      mem_rd  <= '0;
      wb_v    <= 1'b0;
      wb_wen  <= 1'b0;
      wb_rd   <= '0;
    end else begin
      wb_v     <= mem_v;
      wb_wen   <= mem_wen;
      wb_rd    <= mem_rd;
      mem_v    <= ex_v;
      mem_wen  <= ex_wen;
      mem_load <= ex_load;
      mem_rd   <= ex_rd;
      ex_v     <= advance_into_ex;
      ex_wen   <= advance_into_ex && id_wen;
      ex_load  <= advance_into_ex && id_load;
      ex_rd    <= advance_into_ex ? id_rd : '0;
      ex_rs    <= advance_into_ex ? id_rs : '0;
      ex_rt    <= advance_into_ex ? id_rt : '0;
    end
  end

  // R2
  bubble_empties_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insert_bubble |=> !ex_v);

  // R1
  empty_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!ex_v && !mem_v && !wb_v));

endmodule

// File: rtl/hz_detect.sv
module hz_detect #(
  parameter int REG_W    = 5,
  parameter bit FWD_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic             id_branch,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             ex_v,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_v,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] mem_rd,
  output logic             stall
);

  // A producer is a dependence only if it is real, writes, and the
  // register is not the hard-wired zero register.
  function automatic logic reg_hit(input logic v, input logic we,
                                   input logic [REG_W-1:0] dst,
                                   input logic [REG_W-1:0] src);
    return v && we && (src != '0) && (dst == src);
  endfunction

  // Named dependence events.
  logic dep_ex, dep_mem, dep_ex_load, dep_mem_load;
  assign dep_ex       = reg_hit(ex_v, ex_wen, ex_rd, id_rs) ||
                        reg_hit(ex_v, ex_wen, ex_rd, id_rt);
  assign dep_mem      = reg_hit(mem_v, mem_wen, mem_rd, id_rs) ||
                        reg_hit(mem_v, mem_wen, mem_rd, id_rt);
  assign dep_ex_load  = dep_ex && ex_load;
  assign dep_mem_load = dep_mem && mem_load;

  logic plain_stall, fwd_stall;
  assign plain_stall = id_valid && (dep_ex || dep_mem);
  assign fwd_stall   = id_valid && (id_branch ? (dep_ex || dep_mem_load)
                                              : dep_ex_load);

  generate
    if (FWD_MODE) begin : g_fwd
      assign stall = fwd_stall;

      // R7
      alu_stall_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !id_branch) |-> ex_load);

      // R7
      load_use_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !id_branch) |=> !(stall && !id_branch && ex_v));
    end else begin : g_plain
      assign stall = plain_stall;
    end
  endgenerate

  // R4
  zero_sources_never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0 && id_rt == '0) |-> !stall);

  // R2
  stall_needs_older_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((ex_v && ex_wen) || (mem_v && mem_wen)));

endmodule

// File: rtl/hz_forward.sv
module hz_forward
  import hz_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter bit FWD_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic             id_branch,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             stall,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic             mem_v,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_v,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_rd,
  output fwd_sel_e         ex_fwd_a,
  output fwd_sel_e         ex_fwd_b,
  output logic             br_fwd_a,
  output logic             br_fwd_b
);

  function automatic logic reg_hit(input logic v, input logic we,
                                   input logic [REG_W-1:0] dst,
                                   input logic [REG_W-1:0] src);
    return v && we && (src != '0) && (dst == src);
  endfunction

  // Nearest producer wins: memory stage before writeback stage.
  function automatic fwd_sel_e pick_source(input logic from_mem,
                                           input logic from_wb);
    if (from_mem)     return FWD_MEM;
    else if (from_wb) return FWD_WB;
    else              return FWD_RF;
  endfunction

  logic a_from_mem, a_from_wb, b_from_mem, b_from_wb;
  assign a_from_mem = reg_hit(mem_v, mem_wen, mem_rd, ex_rs);
  assign a_from_wb  = reg_hit(wb_v,  wb_wen,  wb_rd,  ex_rs);
  assign b_from_mem = reg_hit(mem_v, mem_wen, mem_rd, ex_rt);
  assign b_from_wb  = reg_hit(wb_v,  wb_wen,  wb_rd,  ex_rt);

  logic br_resolving;
  assign br_resolving = id_valid && id_branch && !stall;

  logic br_a_hit, br_b_hit;
  assign br_a_hit = br_resolving && reg_hit(mem_v, mem_wen, mem_rd, id_rs);
  assign br_b_hit = br_resolving && reg_hit(mem_v, mem_wen, mem_rd, id_rt);

  generate
    if (FWD_MODE) begin : g_fwd
      assign ex_fwd_a = pick_source(a_from_mem, a_from_wb);
      assign ex_fwd_b = pick_source(b_from_mem, b_from_wb);
      assign br_fwd_a = br_a_hit;
      assign br_fwd_b = br_b_hit;
    end else begin : g_plain
      assign ex_fwd_a = FWD_RF;
      assign ex_fwd_b = FWD_RF;
      assign br_fwd_a = 1'b0;
      assign br_fwd_b = 1'b0;
    end
  endgenerate

  // R9
  mem_select_has_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a == FWD_MEM) |-> (mem_v && mem_wen && ex_rs != '0 && mem_rd == ex_rs));

  // R9
  wb_select_has_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_b == FWD_WB) |-> (wb_v && wb_wen && ex_rt != '0 && wb_rd == ex_rt));

  // R8
  branch_never_takes_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fwd_a || br_fwd_b) |-> !mem_load);

endmodule

// File: rtl/hz_branch.sv
module hz_branch #(
  parameter bit FWD_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic id_valid,
  input  logic id_branch,
  input  logic br_taken,
  input  logic stall,
  output logic fetch_hold,
  output logic ifid_flush,
  output logic pc_redirect
);

  // A branch resolves in the cycle it leaves decode.
  logic br_resolving;
  assign br_resolving = id_valid && id_branch && !stall;

  assign pc_redirect = br_resolving && br_taken;

  generate
    if (FWD_MODE) begin : g_delay_slot
      // The instruction fetched beside the branch is its delay slot.
      assign ifid_flush = 1'b0;
      assign fetch_hold = stall;
    end else begin : g_idle_fetch
      // The fetch slot beside a resolving branch is discarded; a not-taken
      // branch keeps the PC so the fall-through is fetched next cycle.
      assign ifid_flush = br_resolving;
      assign fetch_hold = stall || (br_resolving && !br_taken);
    end
  endgenerate

  // R11
  no_flush_or_redirect_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!ifid_flush && !pc_redirect));

  // R5
  redirect_needs_taken_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> (id_valid && id_branch && br_taken));

  // R5
  hold_and_redirect_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_hold && pc_redirect));

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter bit FWD_MODE = 1'b0,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] id_rd,
  input  logic             id_wen,
  input  logic             id_load,
  input  logic             id_branch,
  input  logic             br_taken,
  output logic             fetch_hold,
  output logic             idex_bubble,
  output logic             ifid_flush,
  output logic             pc_redirect,
  output logic [1:0]       ex_fwd_a,
  output logic [1:0]       ex_fwd_b,
  output logic             br_fwd_a,
  output logic             br_fwd_b
);

  logic             stall;
  logic             ex_v, ex_wen, ex_load;
  logic [REG_W-1:0] ex_rd, ex_rs, ex_rt;
  logic             mem_v, mem_wen, mem_load;
  logic [REG_W-1:0] mem_rd;
  logic             wb_v, wb_wen;
  logic [REG_W-1:0] wb_rd;
  fwd_sel_e         sel_a, sel_b;

  hz_stage_track #(.REG_W(REG_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd),
    .id_wen(id_wen), .id_load(id_load), .insert_bubble(stall),
    .ex_v(ex_v), .ex_wen(ex_wen), .ex_load(ex_load),
    .ex_rd(ex_rd), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .mem_v(mem_v), .mem_wen(mem_wen), .mem_load(mem_load), .mem_rd(mem_rd),
    .wb_v(wb_v), .wb_wen(wb_wen), .wb_rd(wb_rd)
  );

  hz_detect #(.REG_W(REG_W), .FWD_MODE(FWD_MODE)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_branch(id_branch), .id_rs(id_rs), .id_rt(id_rt),
    .ex_v(ex_v), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rd(ex_rd),
    .mem_v(mem_v), .mem_wen(mem_wen), .mem_load(mem_load), .mem_rd(mem_rd),
    .stall(stall)
  );

  hz_forward #(.REG_W(REG_W), .FWD_MODE(FWD_MODE)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_branch(id_branch), .id_rs(id_rs), .id_rt(id_rt),
    .stall(stall), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .mem_v(mem_v), .mem_wen(mem_wen), .mem_load(mem_load), .mem_rd(mem_rd),
    .wb_v(wb_v), .wb_wen(wb_wen), .wb_rd(wb_rd),
    .ex_fwd_a(sel_a), .ex_fwd_b(sel_b),
    .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b)
  );

  hz_branch #(.FWD_MODE(FWD_MODE)) u_br (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_branch(id_branch), .br_taken(br_taken),
    .stall(stall),
    .fetch_hold(fetch_hold), .ifid_flush(ifid_flush), .pc_redirect(pc_redirect)
  );

  assign idex_bubble = stall;
  assign ex_fwd_a    = sel_a;
  assign ex_fwd_b    = sel_b;

  // R3
  wb_writer_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && wb_v) |-> ((ex_v && ex_wen) || (mem_v && mem_wen)));

endmodule

// File: tb/sim_hazard_ctrl.sv
module sim_hazard_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG      = 12;
  localparam int NTAB       = 8;
  localparam int NCYC       = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       i_valid[2], i_wen[2], i_load[2], i_branch[2], i_taken[2];
  logic [4:0] i_rs[2], i_rt[2], i_rd[2];
  logic       o_hold[2], o_bub[2], o_flush[2], o_redir[2], o_bfa[2], o_bfb[2];
  logic [1:0] o_fa[2], o_fb[2];

  hazard_ctrl #(.NUM_REGS(32), .FWD_MODE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(i_valid[0]), .id_rs(i_rs[0]), .id_rt(i_rt[0]),
    .id_rd(i_rd[0]), .id_wen(i_wen[0]), .id_load(i_load[0]), .id_branch(i_branch[0]),
    .br_taken(i_taken[0]), .fetch_hold(o_hold[0]), .idex_bubble(o_bub[0]),
    .ifid_flush(o_flush[0]), .pc_redirect(o_redir[0]), .ex_fwd_a(o_fa[0]),
    .ex_fwd_b(o_fb[0]), .br_fwd_a(o_bfa[0]), .br_fwd_b(o_bfb[0]));

  hazard_ctrl #(.NUM_REGS(32), .FWD_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .id_valid(i_valid[1]), .id_rs(i_rs[1]), .id_rt(i_rt[1]),
    .id_rd(i_rd[1]), .id_wen(i_wen[1]), .id_load(i_load[1]), .id_branch(i_branch[1]),
    .br_taken(i_taken[1]), .fetch_hold(o_hold[1]), .idex_bubble(o_bub[1]),
    .ifid_flush(o_flush[1]), .pc_redirect(o_redir[1]), .ex_fwd_a(o_fa[1]),
    .ex_fwd_b(o_fb[1]), .br_fwd_a(o_bfa[1]), .br_fwd_b(o_bfb[1]));

  // Scripted program.
  int p_rs[NPROG], p_rt[NPROG], p_rd[NPROG], p_tgt[NPROG];
  bit p_we[NPROG], p_ld[NPROG], p_br[NPROG], p_tk[NPROG];

  // Reference model state per mode: instruction index per stage, -1 empty.
  int st_d[2], st_e[2], st_m[2], st_w[2], st_pc[2];
  int got_e[2][NPROG], got_w[2][NPROG];
  int exp_e[2][NTAB];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp, input int mode);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s mode %0d %s: actual %0d expected %0d", req, mode, what, act, exp);
    end
  endtask

  task automatic set_instr(input int i, input int rs, input int rt, input int rd,
                           input bit we, input bit ld, input bit br, input bit tk,
                           input int tgt);
    p_rs[i] = rs; p_rt[i] = rt; p_rd[i] = rd; p_we[i] = we;
    p_ld[i] = ld; p_br[i] = br; p_tk[i] = tk; p_tgt[i] = tgt;
  endtask

  function automatic bit writes(input int idx, input int r);
    if (idx < 0) return 1'b0;
    return p_we[idx] && r != 0 && p_rd[idx] == r;
  endfunction

  function automatic bit is_load(input int idx);
    return idx >= 0 && p_ld[idx];
  endfunction

  task automatic drive(input int m);
    int d;
    d = st_d[m];
    i_valid[m]  = d >= 0;
    i_rs[m]     = d >= 0 ? 5'(p_rs[d]) : 5'd0;
    i_rt[m]     = d >= 0 ? 5'(p_rt[d]) : 5'd0;
    i_rd[m]     = d >= 0 ? 5'(p_rd[d]) : 5'd0;
    i_wen[m]    = d >= 0 && p_we[d];
    i_load[m]   = d >= 0 && p_ld[d];
    i_branch[m] = d >= 0 && p_br[d];
    i_taken[m]  = d >= 0 && p_br[d] && p_tk[d];
  endtask

  // Compare outputs with the model's expectation, then advance the model.
  task automatic step(input int m, input int cyc);
    int d, e, mm, w, s_a, s_b;
    bit br, stall, flush, hold, redir, bfa, bfb;
    int fa, fb, nxt;
    d = st_d[m]; e = st_e[m]; mm = st_m[m]; w = st_w[m];
    br = d >= 0 && p_br[d];
    stall = 1'b0;
    if (d >= 0) begin
      s_a = p_rs[d]; s_b = p_rt[d];
      if (m == 0)
        stall = writes(e, s_a) || writes(e, s_b) || writes(mm, s_a) || writes(mm, s_b);
      else if (br)
        stall = writes(e, s_a) || writes(e, s_b) ||
                (is_load(mm) && (writes(mm, s_a) || writes(mm, s_b)));
      else
        stall = is_load(e) && (writes(e, s_a) || writes(e, s_b));
    end
    flush = (m == 0) && br && !stall;
    redir = br && !stall && p_tk[d];
    hold  = stall || (flush && !p_tk[d]);
    bfa = (m == 1) && br && !stall && writes(mm, p_rs[d]);
    bfb = (m == 1) && br && !stall && writes(mm, p_rt[d]);
    fa = 0; fb = 0;
    if (m == 1 && e >= 0) begin
      fa = writes(mm, p_rs[e]) ? 1 : (writes(w, p_rs[e]) ? 2 : 0);
      fb = writes(mm, p_rt[e]) ? 1 : (writes(w, p_rt[e]) ? 2 : 0);
    end
    // R2 R3 R4 R7 R8: stall decision seen on hold/bubble.
    chk(o_bub[m] == stall, stall ? (m == 0 ? "R2" : (br ? "R8" : "R7")) : "R3/R4",
        "idex_bubble", int'(o_bub[m]), int'(stall), m);
    chk(o_hold[m] == hold, (m == 0) ? "R5" : "R6", "fetch_hold", int'(o_hold[m]), int'(hold), m);
    chk(o_flush[m] == flush, stall ? "R11" : ((m == 0) ? "R5" : "R6"), "ifid_flush",
        int'(o_flush[m]), int'(flush), m);
    chk(o_redir[m] == redir, stall ? "R11" : "R6", "pc_redirect",
        int'(o_redir[m]), int'(redir), m);
    chk(o_bfa[m] == bfa && o_bfb[m] == bfb, "R8", "br_fwd_a*2+br_fwd_b",
        2*int'(o_bfa[m]) + int'(o_bfb[m]), 2*int'(bfa) + int'(bfb), m);
    chk(int'(o_fa[m]) == fa && int'(o_fb[m]) == fb, "R9", "ex_fwd_a*4+ex_fwd_b",
        4*int'(o_fa[m]) + int'(o_fb[m]), 4*fa + fb, m);
    // Advance.
    if (mm >= 0) got_w[m][mm] = cyc + 1;
    st_w[m] = mm;
    st_m[m] = e;
    if (stall) begin
      st_e[m] = -1;
    end else begin
      st_e[m] = d;
      if (d >= 0) got_e[m][d] = cyc + 1;
      nxt = (st_pc[m] < NPROG) ? st_pc[m] : -1;
      st_d[m] = flush ? -1 : nxt;
      if (redir)      st_pc[m] = p_tgt[d];
      else if (!hold) st_pc[m] = st_pc[m] + 1;
    end
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // 0 add r1<-r2,r3 | 1 load r4<-[r1] | 2 add r5<-r4,r6 | 3 branch r5,r0 not taken
    // 4 add r7<-r7,r8 | 5 branch r7,r7 taken to 7 | 6 add r9<-r1,r1 | 7 store r9,r5
    // 8 load into r0 | 9 add reads r0,r0 | 10 no-write to r12 | 11 reads r12,r12
    set_instr(0, 2, 3, 1, 1, 0, 0, 0, 0);
    set_instr(1, 1, 0, 4, 1, 1, 0, 0, 0);
    set_instr(2, 4, 6, 5, 1, 0, 0, 0, 0);
    set_instr(3, 5, 0, 0, 0, 0, 1, 0, 0);
    set_instr(4, 7, 8, 7, 1, 0, 0, 0, 0);
    set_instr(5, 7, 7, 0, 0, 0, 1, 1, 7);
    set_instr(6, 1, 1, 9, 1, 0, 0, 0, 0);
    set_instr(7, 9, 5, 0, 0, 0, 0, 0, 0);
    set_instr(8, 7, 0, 0, 1, 1, 0, 0, 0);
    set_instr(9, 0, 0, 11, 1, 0, 0, 0, 0);
    set_instr(10, 0, 0, 12, 0, 0, 0, 0, 0);
    set_instr(11, 12, 12, 13, 1, 0, 0, 0, 0);
    // Hand-worked execute entry cycles (-1: never executes).
    exp_e[0] = '{3, 6, 9, 12, 14, 17, -1, 19};
    exp_e[1] = '{3, 4, 6, 8, 9, 11, 12, 13};

    for (int m = 0; m < 2; m++) begin
      st_d[m] = -1; st_e[m] = -1; st_m[m] = -1; st_w[m] = -1; st_pc[m] = 0;
      for (int i = 0; i < NPROG; i++) begin got_e[m][i] = -1; got_w[m][i] = -1; end
      drive(m);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int m = 0; m < 2; m++) begin
      // R1: idle after reset with no valid decode instruction.
      chk(!o_hold[m] && !o_bub[m] && !o_flush[m] && !o_redir[m] && !o_bfa[m] && !o_bfb[m]
          && o_fa[m] == 2'b00 && o_fb[m] == 2'b00, "R1", "outputs nonzero",
          int'(o_hold[m]) + int'(o_bub[m]) + int'(o_flush[m]) + int'(o_redir[m]), 0, m);
    end

    for (int cyc = 1; cyc <= NCYC; cyc++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) drive(m);
      #1;
      for (int m = 0; m < 2; m++) step(m, cyc);
    end

    // R10: stage occupancy tables for both variants.
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < NTAB; i++) begin
        chk(got_e[m][i] == exp_e[m][i], "R10", $sformatf("execute cycle of instr %0d", i),
            got_e[m][i], exp_e[m][i], m);
        chk(got_w[m][i] == ((exp_e[m][i] < 0) ? -1 : exp_e[m][i] + 2), "R10",
            $sformatf("writeback cycle of instr %0d", i), got_w[m][i],
            (exp_e[m][i] < 0) ? -1 : exp_e[m][i] + 2, m);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule